// File: doc/BRIEF.md
# Accumulator Saturation and Rounding Unit

This block is the write-back stage of a 40-bit signed fractional accumulator. The accumulator holds a 1.31 fractional value with eight guard bits above it. Each enabled cycle, the block adds an optional 40-bit addend to the incoming accumulator value. It then limits the sum according to the selected saturation policy and registers the updated accumulator.

Saturation can be switched off, or it can clamp at one of two points. The normal point keeps the result inside the 1.31 range. The wide point keeps it inside the full 40-bit range. Two per-operation flags report overflow:
- one flag reports that the exact sum left the 1.31 range and reached the guard bits;
- the other reports that the exact sum left the 40-bit range.

A sticky flag records that a clamp has happened.

From the same updated accumulator, the block also produces the 16-bit word that a store would write. This word is rounded in one of two ways, conventional or convergent (ties to even). It is then limited to the 1.15 range.

Top module: `acc_satrnd`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become zero at that edge.
- R2: Outputs are registered with one cycle of latency. With `sat_en` low, `acc_out` becomes the 40-bit wrapped value of `acc_in` plus `addend`. When `add_en` is low, `addend` has no effect and the sum is `acc_in` alone.
- R3: With `sat_en` high and `sat_mode`=1 (wide), a sum above 2^39-1 gives `acc_out`=0x7FFFFFFFFF. A sum below -2^39 gives 0x8000000000.
- R4: With `sat_en` high and `sat_mode`=0 (normal), a sum above 2^31-1 gives `acc_out`=0x007FFFFFFF. A sum below -2^31 gives 0xFF80000000.
- R5: `guard_ovf` is 1 exactly when the exact sum lies outside [-2^31, 2^31-1]. This holds whatever the saturation settings are.
- R6: `wide_ovf` is 1 exactly when the exact sum lies outside [-2^39, 2^39-1].
- R7: With `rnd_mode`=0 (conventional), the rounded value is the updated accumulator's bits 39:16, plus 1 when bit 15 is 1.
- R8: With `rnd_mode`=1 (convergent), the rounded value is bits 39:16, plus 1 in two cases: when bits 15:0 exceed 0x8000, or when bits 15:0 equal 0x8000 and bit 16 is 1.
- R9: `word_out` is the rounded value when that value lies in [-32768, 32767]. Above that range `word_out` is 0x7FFF, and below it `word_out` is 0x8000.
- R10: `sat_sticky` is set by any enabled operation in which R3, R4 or R9 clamps a value. Otherwise, `sat_clr` clears it. When a clamp and `sat_clr` fall in the same cycle, the flag ends up set.
- R11: With `op_en` low, `acc_out`, `word_out`, `guard_ovf` and `wide_ovf` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Perform an operation this cycle |
| acc_in | input | 40 | Current accumulator value |
| addend | input | 40 | Value added when `add_en` is high |
| add_en | input | 1 | Include `addend` in the sum |
| sat_en | input | 1 | Enable accumulator saturation |
| sat_mode | input | 1 | 0: clamp at 1.31 range, 1: clamp at 40-bit range |
| rnd_mode | input | 1 | 0: conventional rounding, 1: convergent rounding |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| acc_out | output | 40 | Updated accumulator |
| word_out | output | 16 | Rounded, limited 1.15 word |
| guard_ovf | output | 1 | Last sum reached the guard bits |
| wide_ovf | output | 1 | Last sum overflowed 40 bits |
| sat_sticky | output | 1 | A clamp has occurred since the last clear |

## Verification
A clamp and a `sat_clr` can meet in one cycle. So can a saturating accumulator clamp and a word clamp, in any mix.

The bench provokes the first case with a directed step: a 32-bit overflowing add issued together with `sat_clr`. The flag must read 1 afterwards, and a following clear-only step must drop it. Random steps assert `sat_clr` in about one cycle in ten, alongside values drawn near both saturation points and at the 0x8000 rounding tie. A behavioural model built on 64-bit integers judges every cycle and every output.

// File: rtl/acc_satrnd_pkg.sv
package acc_satrnd_pkg;
  typedef enum logic {
    SAT_NORMAL = 1'b0,
    SAT_WIDE   = 1'b1
  } sat_mode_e;

  typedef enum logic {
    RND_CONVENTIONAL = 1'b0,
    RND_CONVERGENT   = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_sat_add.sv
module acc_sat_add
  import acc_satrnd_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] addend,
  input  logic             add_en,
  input  logic             sat_en,
  input  logic             sat_mode,
  output logic [ACC_W-1:0] res,
  output logic             guard_hit,
  output logic             wide_hit,
  output logic             clamped
);
  localparam int NORM_MSB = ACC_W - GUARD_W - 1;
  localparam logic [ACC_W-1:0] MAX_WIDE = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MIN_WIDE = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] MAX_NORM = {{(GUARD_W+1){1'b0}}, {NORM_MSB{1'b1}}};
  localparam logic [ACC_W-1:0] MIN_NORM = {{(GUARD_W+1){1'b1}}, {NORM_MSB{1'b0}}};

  logic [ACC_W:0] sum;
  logic [ACC_W:0] add_term;
  logic           neg;

  always_comb begin
    add_term  = add_en ? {addend[ACC_W-1], addend} : '0;
    sum       = {acc_in[ACC_W-1], acc_in} + add_term;
    neg       = sum[ACC_W];
    wide_hit  = sum[ACC_W] ^ sum[ACC_W-1];
    guard_hit = !((&sum[ACC_W:NORM_MSB]) || (~|sum[ACC_W:NORM_MSB]));
    res       = sum[ACC_W-1:0];
    clamped   = 1'b0;
    if (sat_en) begin
      if (sat_mode == SAT_WIDE) begin
        if (wide_hit) begin
          res     = neg ? MIN_WIDE : MAX_WIDE;
          clamped = 1'b1;
        end
      end else if (guard_hit) begin
        res     = neg ? MIN_NORM : MAX_NORM;
        clamped = 1'b1;
      end
    end
  end

  // R3: a wide clamp keeps the sign both operands shared
  a_r3_wide_sign: assert property (@(posedge clk) disable iff (rst)
    (sat_en && sat_mode == SAT_WIDE && wide_hit) |-> (res[ACC_W-1] == acc_in[ACC_W-1]));
endmodule

// File: rtl/acc_round_store.sv
module acc_round_store
  import acc_satrnd_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc_val,
  input  logic              rnd_mode,
  output logic [WORD_W-1:0] word,
  output logic              clamped
);
  localparam int LOW_W = ACC_W - GUARD_W - WORD_W;
  localparam int HI_W  = ACC_W - LOW_W;
  localparam logic [LOW_W-1:0]  HALF     = {1'b1, {(LOW_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic [LOW_W-1:0] low;
  logic             up;
  logic [HI_W:0]    q;
  logic             in_range;

  always_comb begin
    low = acc_val[LOW_W-1:0];
    if (rnd_mode == RND_CONVERGENT)
      up = (low > HALF) || ((low == HALF) && acc_val[LOW_W]);
    else
      up = low[LOW_W-1];
    q        = {acc_val[ACC_W-1], acc_val[ACC_W-1:LOW_W]} + {{HI_W{1'b0}}, up};
    in_range = (&q[HI_W:WORD_W-1]) || (~|q[HI_W:WORD_W-1]);
    clamped  = !in_range;
    if (in_range)  word = q[WORD_W-1:0];
    else if (q[HI_W]) word = WORD_MIN;
    else           word = WORD_MAX;
  end

  // R8: an exact tie in convergent mode lands on an even word
  a_r8_tie_even: assert property (@(posedge clk) disable iff (rst)
    (rnd_mode == RND_CONVERGENT && low == HALF && !clamped) |-> !word[0]);
endmodule

// File: rtl/acc_satrnd.sv
module acc_satrnd
  import acc_satrnd_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_en,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [ACC_W-1:0]  addend,
  input  logic              add_en,
  input  logic              sat_en,
  input  logic              sat_mode,
  input  logic              rnd_mode,
  input  logic              sat_clr,
  output logic [ACC_W-1:0]  acc_out,
  output logic [WORD_W-1:0] word_out,
  output logic              guard_ovf,
  output logic              wide_ovf,
  output logic              sat_sticky
);
  localparam int NORM_MSB = ACC_W - GUARD_W - 1;

  logic [ACC_W-1:0]  acc_next;
  logic [WORD_W-1:0] word_next;
  logic              guard_hit, wide_hit, acc_clamp, word_clamp;

  acc_sat_add #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_add (
    .clk(clk), .rst(rst), .acc_in(acc_in), .addend(addend), .add_en(add_en),
    .sat_en(sat_en), .sat_mode(sat_mode), .res(acc_next),
    .guard_hit(guard_hit), .wide_hit(wide_hit), .clamped(acc_clamp)
  );

  acc_round_store #(.ACC_W(ACC_W), .GUARD_W(GUARD_W), .WORD_W(WORD_W)) u_rnd (
    .clk(clk), .rst(rst), .acc_val(acc_next), .rnd_mode(rnd_mode),
    .word(word_next), .clamped(word_clamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out    <= '0;
      word_out   <= '0;
      guard_ovf  <= 1'b0;
      wide_ovf   <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      if (op_en) begin
        acc_out   <= acc_next;
        word_out  <= word_next;
        guard_ovf <= guard_hit;
        wide_ovf  <= wide_hit;
      end
      if (op_en && (acc_clamp || word_clamp)) sat_sticky <= 1'b1;
      else if (sat_clr)                       sat_sticky <= 1'b0;
    end
  end

  // R6: leaving 40 bits implies leaving the 1.31 range
  a_r6_wide_implies_guard: assert property (@(posedge clk) disable iff (rst)
    wide_ovf |-> guard_ovf);

  // R4: normal-mode saturation never leaves guard bits unequal
  a_r4_normal_range: assert property (@(posedge clk) disable iff (rst)
    (op_en && sat_en && sat_mode == SAT_NORMAL) |=>
      ((&acc_out[ACC_W-1:NORM_MSB]) || (~|acc_out[ACC_W-1:NORM_MSB])));

  // R10: sticky flag persists without a clear
  a_r10_sticky_keeps: assert property (@(posedge clk) disable iff (rst)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  // R11: idle cycles leave the datapath outputs untouched
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !op_en |=> ($stable(acc_out) && $stable(word_out) && $stable(guard_ovf) && $stable(wide_ovf)));
endmodule

// File: tb/acc_satrnd_bench.sv
module acc_satrnd_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_en = 1'b0, add_en = 1'b0, sat_en = 1'b0, sat_mode = 1'b0;
  logic        rnd_mode = 1'b0, sat_clr = 1'b0;
  logic [39:0] acc_in = '0, addend = '0;
  logic [39:0] acc_out;
  logic [15:0] word_out;
  logic        guard_ovf, wide_ovf, sat_sticky;

  int checks = 0;
  int errors = 0;

  logic [39:0] m_acc = '0;
  logic [15:0] m_word = '0;
  logic        m_guard = 1'b0, m_wide = 1'b0, m_sticky = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_satrnd u_acc_satrnd (
    .clk(clk), .rst(rst), .op_en(op_en), .acc_in(acc_in), .addend(addend),
    .add_en(add_en), .sat_en(sat_en), .sat_mode(sat_mode), .rnd_mode(rnd_mode),
    .sat_clr(sat_clr), .acc_out(acc_out), .word_out(word_out),
    .guard_ovf(guard_ovf), .wide_ovf(wide_ovf), .sat_sticky(sat_sticky)
  );

  task automatic check(input string tag, input string what, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [39:0] a, input logic [39:0] b, input logic ae,
                      input logic se, input logic sm, input logic rm,
                      input logic en, input logic clr);
    longint s, r, v, q, lo;
    logic   g, w, ca, cw, up;
    string  t_acc, t_word;
    acc_in = a; addend = b; add_en = ae; sat_en = se; sat_mode = sm;
    rnd_mode = rm; op_en = en; sat_clr = clr;
    @(posedge clk);
    @(negedge clk);
    s = longint'($signed(a)) + (ae ? longint'($signed(b)) : 64'sd0);
    g = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    w = (s > 64'sd549755813887) || (s < -64'sd549755813888);
    ca = 1'b0;
    if (se && sm && w) begin
      r = (s > 0) ? 64'sd549755813887 : -64'sd549755813888; ca = 1'b1;
    end else if (se && !sm && g) begin
      r = (s > 0) ? 64'sd2147483647 : -64'sd2147483648; ca = 1'b1;
    end else r = s;
    v  = longint'($signed(r[39:0]));
    q  = v >>> 16;
    lo = v & 64'sh0000_0000_0000_FFFF;
    up = rm ? ((lo > 64'sd32768) || (lo == 64'sd32768 && q[0])) : (lo >= 64'sd32768);
    q  = q + (up ? 64'sd1 : 64'sd0);
    cw = (q > 64'sd32767) || (q < -64'sd32768);
    t_acc  = ca ? (sm ? "R3" : "R4") : "R2";
    t_word = cw ? "R9" : (rm ? "R8" : "R7");
    if (en) begin
      m_acc   = r[39:0];
      m_word  = (q > 64'sd32767) ? 16'h7FFF : ((q < -64'sd32768) ? 16'h8000 : q[15:0]);
      m_guard = g;
      m_wide  = w;
    end else begin
      t_acc = "R11"; t_word = "R11";
    end
    if (en && (ca || cw)) m_sticky = 1'b1;
    else if (clr)         m_sticky = 1'b0;
    check(t_acc, "acc_out", acc_out, m_acc);
    check(t_word, "word_out", {24'd0, word_out}, {24'd0, m_word});
    check(en ? "R5" : "R11", "guard_ovf", {39'd0, guard_ovf}, {39'd0, m_guard});
    check(en ? "R6" : "R11", "wide_ovf", {39'd0, wide_ovf}, {39'd0, m_wide});
    check("R10", "sat_sticky", {39'd0, sat_sticky}, {39'd0, m_sticky});
  endtask

  function automatic logic [39:0] pick_value();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    case ($urandom_range(0, 5))
      0: return t[39:0];
      1: return {1'b0, {39{1'b1}}} - {32'd0, t[7:0]};
      2: return {{25{t[15]}}, t[14:0]};
      3: return {t[39:16], 16'h8000};
      4: return {{9{t[0]}}, {31{~t[0]}}} + {{38{t[2]}}, t[2:1]};
      default: return {{8{t[31]}}, t[31:0]};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "acc_out", acc_out, 40'd0);
    check("R1", "word_out", {24'd0, word_out}, 40'd0);
    check("R1", "flags", {37'd0, guard_ovf, wide_ovf, sat_sticky}, 40'd0);

    // R7/R8: tie with bit 16 clear and set, both rounding modes
    step(40'h00_0000_8000, '0, 0, 0, 0, 0, 1, 0);
    step(40'h00_0000_8000, '0, 0, 0, 0, 1, 1, 0);
    step(40'h00_0001_8000, '0, 0, 0, 0, 0, 1, 0);
    step(40'h00_0001_8000, '0, 0, 0, 0, 1, 1, 0);
    step(40'hFF_FFFE_8000, '0, 0, 0, 0, 1, 1, 0);
    // R2: addend ignored when add_en is low
    step(40'h00_1234_5678, 40'h7F_FFFF_FFFF, 0, 1, 0, 0, 1, 0);
    // R5: guard overflow without saturation
    step(40'h00_7FFF_FFFF, 40'h00_0000_0001, 1, 0, 0, 0, 1, 0);
    step(40'h00_0000_0000, '0, 0, 0, 0, 0, 1, 1);
    // R4: normal saturation, with a same-cycle clear (R10: set wins)
    step(40'h00_7FFF_FFFF, 40'h00_0000_0001, 1, 1, 0, 0, 1, 1);
    step(40'hFF_8000_0000, 40'hFF_FFFF_FFFF, 1, 1, 0, 1, 1, 0);
    step(40'h00_0000_0000, '0, 0, 0, 0, 0, 0, 1);
    // R3/R6: wide saturation both directions
    step(40'h7F_FFFF_FFFF, 40'h00_0000_0001, 1, 1, 1, 0, 1, 0);
    step(40'h80_0000_0000, 40'hFF_FFFF_FFFF, 1, 1, 1, 0, 1, 1);
    step(40'h80_0000_0000, 40'hFF_FFFF_FFFF, 1, 0, 1, 0, 1, 1);
    // R9: word clamp without accumulator saturation
    step(40'h00_8000_0000, '0, 0, 0, 0, 0, 1, 1);
    step(40'hFF_7FFF_0000, '0, 0, 0, 0, 1, 1, 1);
    step(40'h00_7FFF_8000, '0, 0, 0, 0, 0, 1, 1);
    // R11: idle cycles hold outputs
    step(40'h12_3456_789A, 40'h1, 1, 0, 0, 0, 0, 0);
    step(40'h00_0000_0000, '0, 0, 0, 0, 0, 1, 1);

    for (int i = 0; i < 4000; i++) begin
      step(pick_value(), pick_value(), 1'($urandom_range(0, 3) != 0),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) != 0),
           1'($urandom_range(0, 9) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule